// File: doc/BRIEF.md
# Circular Debug Trace Buffer

This block keeps a rolling history of core state for a debugger. On every clock cycle that capture is enabled, it stores one 256-bit snapshot into a ring of `DEPTH` entries. The write position advances by one with each capture and wraps around, and a toggle flag flips on each wrap. A host can tell how far the ring has moved from that flag and from the reported write position.

There are two read paths.

- **Host path.** A host sets a 32-bit cursor through a small register port. It then pulls 64-bit slices of the selected entry through a window register. The cursor steps forward on its own each time a window read ends, so a host can stream a whole entry, and then the next one, without rewriting the cursor.
- **Tap path.** A free-running tap address input returns a 64-bit slice on its own output.

Capture stops while bit 31 of either the cursor or the tap address is set. This lets a debugger freeze the history before reading it out.

Top module: `trace_ring`

## Requirements
- R1: While reset is held, the write pointer and toggle are zero, the cursor is zero, and the tap data output is zero.
- R2: A snapshot is captured only in a cycle where bit 31 of the cursor and bit 31 of the tap address are both clear. While either bit is set, the reported write position does not move.
- R3: Each capture stores the snapshot at the write pointer and then increments it. After entry `DEPTH-1` the pointer returns to 0 and `wrap_o` inverts.
- R4: The tap path reads the entry indexed by tap address bits [IB+1:2], where IB = log2(DEPTH). The slice appears on `tap_data_o` three clock edges after the address is applied, provided no host readback is in flight.
- R5: Address bits [1:0] pick the 64-bit slice, on both read paths. Value k returns entry bits [64k+63:64k].
- R6: A rising-edge write to register 6 (cursor) loads the cursor from write data bits [31:0] and starts a readback. Three clock edges later, the selected slice is held for register 7 (window).
- R7: When an access to register 7 ends, the low IB+2 bits of the cursor are incremented by one, wrapping within that field, and a new readback starts. Cursor bits above the field, bit 31 included, are unchanged.
- R8: `wr_pos_o` carries the write pointer in bits [IB-1:0] and a 1 in bit IB. All higher bits are zero.
- R9: Reading register 6 returns the cursor in bits [31:0] and `wr_pos_o` in bits [63:32]. Any register address other than 6 and 7 reads as zero.
- R10: `hack_o` is high in exactly the cycles where `hreq_i` is high.
- R11: Write side effects occur only in the first cycle of a request. Holding `hreq_i` high while `hwdata_i` changes does not alter the cursor again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hreq_i | input | 1 | Host access request |
| hwe_i | input | 1 | Host access is a write |
| haddr_i | input | 4 | Host register address (6 = cursor, 7 = window) |
| hwdata_i | input | 64 | Host write data |
| hrdata_o | output | 64 | Host read data |
| hack_o | output | 1 | Host acknowledge |
| snap_i | input | 256 | Snapshot captured each enabled cycle |
| tap_addr_i | input | 32 | Tap read address; bit 31 freezes capture |
| tap_data_o | output | 64 | Tap read slice |
| wr_pos_o | output | 32 | Reported write position |
| wrap_o | output | 1 | Toggles on each pointer wrap |

## Verification
The hardest state to reach is a cursor increment that overflows its IB+2-bit field while bit 31 stays set. In that state, the next window read must come from entry 0, slice 0, and the ring must stay frozen. The bench gets there by freezing the ring through the cursor itself, parking the cursor on the last slice of the last entry, and issuing two back-to-back window reads. A scoreboard of expected slices is taken from a bench-side copy of the ring, which is filled from the snapshots the bench drove in the cycles it predicted as captures.

// File: rtl/trace_pkg.sv
package trace_pkg;
   localparam int ADDR_W  = 32;
   localparam int SLICE_W = 64;
   localparam int SLICES  = 4;
   localparam int SEL_W   = $clog2(SLICES);
   localparam int ENTRY_W = SLICE_W * SLICES;
   localparam int REG_W   = 4;

   localparam logic [REG_W-1:0] REG_CURSOR = 4'h6;
   localparam logic [REG_W-1:0] REG_WINDOW = 4'h7;
endpackage

// File: rtl/trace_wptr.sv
module trace_wptr
   import trace_pkg::*;
#(
   parameter int DEPTH = 512,
   localparam int IB = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wen_i,
   output logic [IB-1:0]     wptr_o,
   output logic              wrap_o,
   output logic [ADDR_W-1:0] wr_pos_o
);
   localparam logic [IB-1:0] LAST = IB'(DEPTH - 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("trace_wptr: DEPTH must be a power of two of at least 2");
      end
      if (IB + 1 >= ADDR_W) begin : g_bad_width
         $error("trace_wptr: DEPTH too large for the reported position");
      end
   endgenerate

   logic [IB-1:0] ptr_q;
   logic          tog_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
         tog_q <= 1'b0;
      end else if (wen_i) begin
         ptr_q <= ptr_q + 1'b1;
         if (ptr_q == LAST) tog_q <= ~tog_q;
      end
   end

   always_comb begin
      wr_pos_o           = '0;
      wr_pos_o[IB-1:0]   = ptr_q;
      wr_pos_o[IB]       = 1'b1;
   end

   assign wptr_o = ptr_q;
   assign wrap_o = tog_q;

   assert_freeze_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wen_i |=> $stable(ptr_q));
   assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wen_i |=> ptr_q == IB'($past(ptr_q) + 1'b1));
   assert_wrap_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wen_i && ptr_q == LAST) |=> tog_q != $past(tog_q));
   assert_wrap_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wen_i && ptr_q == LAST) |=> $stable(tog_q));
endmodule

// File: rtl/trace_store.sv
module trace_store
   import trace_pkg::*;
#(
   parameter int DEPTH = 512,
   localparam int IB = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               wen_i,
   input  logic [IB-1:0]      wptr_i,
   input  logic [ENTRY_W-1:0] wdata_i,
   input  logic [IB-1:0]      rptr_i,
   output logic [ENTRY_W-1:0] rdata_o
);
   logic [ENTRY_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wen_i) mem[wptr_i] <= wdata_i;
      rdata_o <= mem[rptr_i];
   end
endmodule

// File: rtl/trace_readout.sv
module trace_readout
   import trace_pkg::*;
#(
   parameter int DEPTH = 512,
   localparam int IB = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trig_i,
   input  logic [IB-1:0]      cur_idx_i,
   input  logic [SEL_W-1:0]   cur_sel_i,
   input  logic [IB-1:0]      tap_idx_i,
   input  logic [SEL_W-1:0]   tap_sel_i,
   input  logic [ENTRY_W-1:0] rword_i,
   output logic [IB-1:0]      rptr_o,
   output logic [SLICE_W-1:0] host_data_o,
   output logic [SLICE_W-1:0] tap_data_o
);
   logic [SLICE_W-1:0] slice_w [SLICES];

   genvar g;
   generate
      for (g = 0; g < SLICES; g++) begin : g_slice
         assign slice_w[g] = rword_i[g*SLICE_W +: SLICE_W];
      end
   endgenerate

   logic reading_q, done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reading_q   <= 1'b0;
         done_q      <= 1'b0;
         rptr_o      <= '0;
         host_data_o <= '0;
         tap_data_o  <= '0;
      end else begin
         reading_q <= trig_i;
         done_q    <= reading_q;
         rptr_o    <= trig_i ? cur_idx_i : tap_idx_i;
         if (done_q) host_data_o <= slice_w[cur_sel_i];
         else        tap_data_o  <= slice_w[tap_sel_i];
      end
   end

   assert_window_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !done_q |=> $stable(host_data_o));
   assert_tap_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> $stable(tap_data_o));
endmodule

// File: rtl/trace_host.sv
module trace_host
   import trace_pkg::*;
#(
   parameter int DEPTH = 512,
   localparam int IB    = $clog2(DEPTH),
   localparam int CNT_W = IB + SEL_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hreq_i,
   input  logic               hwe_i,
   input  logic [REG_W-1:0]   haddr_i,
   input  logic [ADDR_W-1:0]  hwdata_lo_i,
   input  logic [SLICE_W-1:0] host_data_i,
   input  logic [ADDR_W-1:0]  wr_pos_i,
   output logic [ADDR_W-1:0]  cursor_o,
   output logic               trig_o,
   output logic [SLICE_W-1:0] hrdata_o,
   output logic               hack_o
);
   generate
      if (CNT_W >= ADDR_W) begin : g_bad_field
         $error("trace_host: cursor step field reaches the stop bit");
      end
      if (2 * ADDR_W != SLICE_W) begin : g_bad_pack
         $error("trace_host: cursor readback packing needs 2*ADDR_W == SLICE_W");
      end
   endgenerate

   logic req_q, act_q0, act_q1;
   logic rise_w, end_w;

   assign rise_w = hreq_i & ~req_q;
   assign end_w  = act_q1 & ~act_q0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q    <= 1'b0;
         act_q0   <= 1'b0;
         act_q1   <= 1'b0;
         trig_o   <= 1'b0;
         cursor_o <= '0;
      end else begin
         req_q  <= hreq_i;
         act_q0 <= hreq_i && (haddr_i == REG_WINDOW);
         act_q1 <= act_q0;
         trig_o <= 1'b0;
         if (rise_w) begin
            if (hwe_i && haddr_i == REG_CURSOR) begin
               cursor_o <= hwdata_lo_i;
               trig_o   <= 1'b1;
            end
         end else if (end_w) begin
            cursor_o[CNT_W-1:0] <= cursor_o[CNT_W-1:0] + 1'b1;
            trig_o              <= 1'b1;
         end
      end
   end

   always_comb begin
      hrdata_o = '0;
      case (haddr_i)
         REG_CURSOR: hrdata_o = {wr_pos_i, cursor_o};
         REG_WINDOW: hrdata_o = host_data_i;
         default:    hrdata_o = '0;
      endcase
   end

   assign hack_o = hreq_i;

   assert_stop_bit_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!rise_w && end_w) |=> cursor_o[ADDR_W-1:CNT_W] == $past(cursor_o[ADDR_W-1:CNT_W]));
   assert_held_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q && !end_w) |=> $stable(cursor_o));
endmodule

// File: rtl/trace_ring.sv
module trace_ring
   import trace_pkg::*;
#(
   parameter int DEPTH = 512
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                hreq_i,
   input  logic                hwe_i,
   input  logic [3:0]          haddr_i,
   input  logic [63:0]         hwdata_i,
   output logic [63:0]         hrdata_o,
   output logic                hack_o,
   input  logic [255:0]        snap_i,
   input  logic [31:0]         tap_addr_i,
   output logic [63:0]         tap_data_o,
   output logic [31:0]         wr_pos_o,
   output logic                wrap_o
);
   localparam int IB = $clog2(DEPTH);

   logic [ADDR_W-1:0]  cursor_w;
   logic               trig_w;
   logic               wen_w;
   logic [IB-1:0]      wptr_w, rptr_w;
   logic [ENTRY_W-1:0] rword_w;
   logic [SLICE_W-1:0] host_data_w;

   logic unused_bits;
   assign unused_bits = ^{hwdata_i[63:ADDR_W], tap_addr_i[ADDR_W-2:IB+SEL_W]};

   assign wen_w = ~cursor_w[ADDR_W-1] & ~tap_addr_i[ADDR_W-1];

   trace_host #(.DEPTH(DEPTH)) u_host (
      .clk(clk), .rst_n(rst_n),
      .hreq_i(hreq_i), .hwe_i(hwe_i), .haddr_i(haddr_i),
      .hwdata_lo_i(hwdata_i[ADDR_W-1:0]),
      .host_data_i(host_data_w), .wr_pos_i(wr_pos_o),
      .cursor_o(cursor_w), .trig_o(trig_w),
      .hrdata_o(hrdata_o), .hack_o(hack_o)
   );

   trace_wptr #(.DEPTH(DEPTH)) u_wptr (
      .clk(clk), .rst_n(rst_n), .wen_i(wen_w),
      .wptr_o(wptr_w), .wrap_o(wrap_o), .wr_pos_o(wr_pos_o)
   );

   trace_store #(.DEPTH(DEPTH)) u_store (
      .clk(clk), .wen_i(wen_w), .wptr_i(wptr_w), .wdata_i(snap_i),
      .rptr_i(rptr_w), .rdata_o(rword_w)
   );

   trace_readout #(.DEPTH(DEPTH)) u_readout (
      .clk(clk), .rst_n(rst_n), .trig_i(trig_w),
      .cur_idx_i(cursor_w[IB+SEL_W-1:SEL_W]), .cur_sel_i(cursor_w[SEL_W-1:0]),
      .tap_idx_i(tap_addr_i[IB+SEL_W-1:SEL_W]), .tap_sel_i(tap_addr_i[SEL_W-1:0]),
      .rword_i(rword_w), .rptr_o(rptr_w),
      .host_data_o(host_data_w), .tap_data_o(tap_data_o)
   );

   assert_ack_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
      hack_o == hreq_i);
endmodule

// File: tb/tb_trace_ring.sv
module tb_trace_ring;
   import trace_pkg::*;
   localparam int DEPTH = 64;
   localparam int IB = $clog2(DEPTH);

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic         rst_n = 1'b0;
   logic         hreq_i = 1'b0, hwe_i = 1'b0;
   logic [3:0]   haddr_i = 4'h0;
   logic [63:0]  hwdata_i = '0;
   logic [63:0]  hrdata_o, tap_data_o;
   logic         hack_o, wrap_o;
   logic [255:0] snap_i = '0;
   logic [31:0]  tap_addr_i = '0;
   logic [31:0]  wr_pos_o;

   trace_ring #(.DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .hreq_i(hreq_i), .hwe_i(hwe_i),
      .haddr_i(haddr_i), .hwdata_i(hwdata_i), .hrdata_o(hrdata_o),
      .hack_o(hack_o), .snap_i(snap_i), .tap_addr_i(tap_addr_i),
      .tap_data_o(tap_data_o), .wr_pos_o(wr_pos_o), .wrap_o(wrap_o)
   );

   logic [255:0] model_mem [DEPTH];
   int           m_wp = 0;
   logic         m_tog = 1'b0;
   logic [31:0]  m_cursor = '0;
   logic [63:0]  exp_q [$];
   int checks = 0, fails = 0, cyc = 0;
   bit finished = 0;

   function automatic logic [255:0] make_snap(int n);
      logic [255:0] s;
      for (int k = 0; k < 4; k++) s[k*64 +: 64] = {16'hD00D, 8'(k), 8'h5A, 32'(n)};
      return s;
   endfunction

   function automatic logic [63:0] mslice(int idx, int sel);
      return model_mem[idx][sel*64 +: 64];
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      snap_i = make_snap(cyc);
   end

   // bench copy of the ring: capture when neither stop bit is set (R2, R3)
   always @(posedge clk) begin
      if (rst_n && !m_cursor[31] && !tap_addr_i[31]) begin
         model_mem[m_wp] = snap_i;
         if (m_wp == DEPTH - 1) begin
            m_wp = 0;
            m_tog = ~m_tog;
         end else m_wp++;
      end
   end

   // scoreboard monitor for window reads
   always @(negedge clk) begin
      #2;
      if (hreq_i && !hwe_i && haddr_i == REG_WINDOW) begin
         chk(hack_o == 1'b1, "R10", 64'(hack_o), 64'd1);
         if (exp_q.size() == 0) chk(1'b0, "R6 empty scoreboard", hrdata_o, 64'd0);
         else begin
            logic [63:0] e;
            e = exp_q.pop_front();
            chk(hrdata_o == e, "R6 R5 R7 window slice", hrdata_o, e);
         end
      end
   end

   task automatic host_write(input logic [3:0] a, input logic [63:0] d);
      @(negedge clk);
      hreq_i = 1'b1; hwe_i = 1'b1; haddr_i = a; hwdata_i = d;
      @(negedge clk);
      hreq_i = 1'b0; hwe_i = 1'b0;
      if (a == REG_CURSOR) m_cursor = d[31:0];
      repeat (4) @(negedge clk);
   endtask

   task automatic reg_read(input logic [3:0] a, output logic [63:0] v);
      @(negedge clk);
      hreq_i = 1'b1; hwe_i = 1'b0; haddr_i = a;
      #2 v = hrdata_o;
      chk(hack_o == 1'b1, "R10", 64'(hack_o), 64'd1);
      @(negedge clk);
      hreq_i = 1'b0;
      #2 chk(hack_o == 1'b0, "R10 idle", 64'(hack_o), 64'd0);
   endtask

   task automatic win_read();
      exp_q.push_back(mslice(int'(m_cursor[IB+1:2]), int'(m_cursor[1:0])));
      @(negedge clk);
      hreq_i = 1'b1; hwe_i = 1'b0; haddr_i = REG_WINDOW;
      @(negedge clk);
      hreq_i = 1'b0;
      m_cursor[IB+1:0] = m_cursor[IB+1:0] + 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic tap_check(input int idx, input int sel, input bit top);
      logic [63:0] e;
      @(negedge clk);
      tap_addr_i = (top ? 32'h8000_0000 : 32'h0) | 32'(idx << 2) | 32'(sel);
      repeat (4) @(negedge clk);
      #2 e = mslice(idx, sel);
      chk(tap_data_o == e, "R4 R5 tap slice", tap_data_o, e);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [63:0] v;
      logic [31:0] p0;
      haddr_i = REG_CURSOR;
      repeat (3) @(negedge clk);
      #2;
      // R1 / R8 reset state
      chk(wr_pos_o == 32'(1 << IB), "R1 R8 reset position", 64'(wr_pos_o), 64'(1 << IB));
      chk(wrap_o == 1'b0, "R1 toggle", 64'(wrap_o), 64'd0);
      chk(tap_data_o == 64'd0, "R1 tap data", tap_data_o, 64'd0);
      chk(hrdata_o == {32'(1 << IB), 32'h0}, "R1 R9 cursor readback", hrdata_o, {32'(1 << IB), 32'h0});
      @(negedge clk);
      rst_n = 1'b1;

      // R3 / R8 pointer advance
      repeat (10) @(negedge clk);
      #2 chk(wr_pos_o == (32'(1 << IB) | 32'd10), "R3 R8 ten captures", 64'(wr_pos_o), 64'((1 << IB) | 10));
      repeat (DEPTH) @(negedge clk);
      #2 chk(wrap_o == 1'b1, "R3 wrap toggle", 64'(wrap_o), 64'd1);
      chk(wr_pos_o[IB-1:0] == IB'(10), "R3 pointer after wrap", 64'(wr_pos_o), 64'd10);

      // R2 freeze through tap stop bit
      @(negedge clk);
      tap_addr_i = 32'h8000_0000;
      @(negedge clk);
      #2 p0 = wr_pos_o;
      repeat (8) @(negedge clk);
      #2 chk(wr_pos_o == p0, "R2 tap freeze", 64'(wr_pos_o), 64'(p0));
      chk(wr_pos_o[IB-1:0] == IB'(m_wp) && wrap_o == m_tog, "R3 model agreement",
          64'({wrap_o, wr_pos_o}), 64'({m_tog, 32'(1 << IB) | 32'(m_wp)}));
      @(negedge clk);
      tap_addr_i = 32'h0;
      repeat (5) @(negedge clk);
      #2 chk(wr_pos_o != p0, "R2 capture resumes", 64'(wr_pos_o), 64'(p0));

      // R2 freeze through cursor stop bit, then host readout
      host_write(REG_CURSOR, 64'hFFFF_0000_8000_0014);
      #2 p0 = wr_pos_o;
      repeat (8) @(negedge clk);
      #2 chk(wr_pos_o == p0, "R2 cursor freeze", 64'(wr_pos_o), 64'(p0));
      reg_read(REG_CURSOR, v);
      chk(v == {wr_pos_o, 32'h8000_0014}, "R9 cursor register", v, {wr_pos_o, 32'h8000_0014});
      reg_read(4'h2, v);
      chk(v == 64'd0, "R9 unmapped reads zero", v, 64'd0);

      // R5 R6 R7 four slices of four entries with auto-increment
      for (int n = 0; n < 16; n++) win_read();
      reg_read(REG_CURSOR, v);
      chk(v[31:0] == 32'h8000_0024, "R7 cursor after sixteen reads", 64'(v[31:0]), 64'h8000_0024);

      // R7 field wrap keeps bit 31
      host_write(REG_CURSOR, 64'(32'h8000_0000 | 32'((DEPTH - 1) << 2) | 32'd3));
      win_read();
      win_read();
      reg_read(REG_CURSOR, v);
      chk(v[31:0] == 32'h8000_0001, "R7 field wrap", 64'(v[31:0]), 64'h8000_0001);

      // R4 R5 tap slices while frozen
      tap_check(7, 0, 1'b0);
      tap_check(7, 2, 1'b0);
      tap_check(DEPTH - 1, 3, 1'b1);
      tap_check(0, 1, 1'b0);
      @(negedge clk);
      tap_addr_i = 32'h0;

      // R11 held request does not rewrite the cursor
      @(negedge clk);
      hreq_i = 1'b1; hwe_i = 1'b1; haddr_i = REG_CURSOR; hwdata_i = 64'h8000_0008;
      @(negedge clk);
      hwdata_i = 64'h8000_0030;
      @(negedge clk);
      hwdata_i = 64'h8000_0044;
      @(negedge clk);
      hreq_i = 1'b0; hwe_i = 1'b0;
      m_cursor = 32'h8000_0008;
      repeat (4) @(negedge clk);
      reg_read(REG_CURSOR, v);
      chk(v[31:0] == 32'h8000_0008, "R11 held write", 64'(v[31:0]), 64'h8000_0008);
      win_read();

      // R2 unfreeze through cursor
      host_write(REG_CURSOR, 64'h0);
      #2 p0 = wr_pos_o;
      repeat (6) @(negedge clk);
      #2 chk(wr_pos_o[IB-1:0] == IB'(p0[IB-1:0] + 6), "R2 R3 resume after cursor clear",
             64'(wr_pos_o), 64'(p0 + 6));

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R6 scoreboard drained", 64'(exp_q.size()), 64'd0);
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule